// File: doc/BRIEF.md
# Programmable Bitwise Truth-Table Unit

This block is a processor execution unit that evaluates a truth table supplied by the instruction independently at every bit position of its operands. In the two register-width modes it works on 64-bit operands. A three-input function takes its 8-entry table from an immediate. A two-input function takes its 4-entry table from the low bits of a third operand at run time, so software can choose the operation dynamically, much as with a reprogrammable logic cell.

Two further modes work on 4-bit condition fields. The first takes three fields and an 8-entry immediate table, where classic condition-register logic uses only a 4-entry table. The second takes two fields and reads its 4-entry table from a third field. In both field modes a 4-bit write mask picks which destination bits receive the new value. Unselected bits keep the destination's previous value, which is supplied on an input, so up to four condition bits change in one operation.

Operands arrive on plain ports. A registered handshake returns the result exactly one clock after the request strobe. A single table-evaluation datapath serves all four modes: a two-input table is widened so that it ignores the third input, and a final merge stage applies the mask.

Top module: `bitlut_unit`

## Requirements
- R1: With mode 2'b00, each result bit i equals imm[{opa[i],opb[i],opc[i]}] for all 64 bits, where opa supplies the index MSB and opc the LSB.
- R2: With mode 2'b00 and imm = 8'hCA, each result bit equals opb where opa is 1 and opc where opa is 0.
- R3: With mode 2'b01, each result bit i equals opc[{opa[i],opb[i]}], where opa supplies the index MSB. Only opc[3:0] serves as the table, and imm, wmask and fld_prev have no effect.
- R4: With mode 2'b10, result bit i (i < 4) equals imm[{opa[i],opb[i],opc[i]}] where wmask[i] is 1. Result bits 63..4 are zero.
- R5: With mode 2'b11, result bit i (i < 4) equals opc[{opa[i],opb[i]}] where wmask[i] is 1. Result bits 63..4 are zero.
- R6: In modes 2'b10 and 2'b11, result bit i (i < 4) equals fld_prev[i] where wmask[i] is 0. A mask of 4'b0000 returns fld_prev unchanged, and 4'b1111 updates all four bits.
- R7: In modes 2'b10 and 2'b11, operand bits 63..4 have no effect on the result.
- R8: Inputs are captured on a clock edge where in_valid is 1. out_valid is 1 in exactly the following cycle. result holds its value while in_valid is 0.
- R9: A synchronous active-high rst clears out_valid and result to zero. It takes priority over an in_valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; operands are sampled when high |
| mode | input | 2 | 00 three-input register, 01 two-input register, 10 three-input field, 11 two-input field |
| opa | input | 64 | First operand (index MSB) |
| opb | input | 64 | Second operand |
| opc | input | 64 | Third operand; in two-input modes its low 4 bits are the table |
| imm | input | 8 | Immediate truth table for three-input modes |
| wmask | input | 4 | Per-bit write mask for field modes |
| fld_prev | input | 4 | Previous destination field value for field modes |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 64 | Registered result |

## Verification
Two behaviours can share a cycle. A new request can be captured while the previous result is on the output, and a reset can arrive together with a request. The bench issues back-to-back requests that change mode every cycle, mixes in idle gaps, and in one cycle raises rst alongside in_valid. On every clock a behavioural model predicts out_valid and result, and the bench compares them. The model must show the reset winning, each back-to-back result belonging to its own request, and the output holding through idle cycles.

// File: rtl/bitlut_pkg.sv
package bitlut_pkg;

    typedef enum logic [1:0] {
        LM_TRI_REG = 2'b00,
        LM_BIN_REG = 2'b01,
        LM_TRI_FLD = 2'b10,
        LM_BIN_FLD = 2'b11
    } lut_mode_e;

    localparam int TRI_ENTRIES = 8;
    localparam int BIN_ENTRIES = 4;

    function automatic logic mode_is_field(lut_mode_e m);
        return m[1];
    endfunction

    function automatic logic mode_is_binary(lut_mode_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/bitlut_table_sel.sv
module bitlut_table_sel
    import bitlut_pkg::*;
#(
    parameter int TW = TRI_ENTRIES,
    parameter int BW = BIN_ENTRIES
) (
    input  lut_mode_e        mode,
    input  logic [TW-1:0]    imm_tbl,
    input  logic [BW-1:0]    rt_tbl,
    output logic [TW-1:0]    tbl
);
    localparam int DUP = TW / BW;

    // A two-input table is widened so that the lowest index bit is ignored:
    // entry j of the wide table is entry j/DUP of the narrow one.
    logic [TW-1:0] widened;

    for (genvar j = 0; j < TW; j++) begin : g_widen
        assign widened[j] = rt_tbl[j / DUP];
    end

    always_comb begin
        if (mode_is_binary(mode)) begin
            tbl = widened;
        end else begin
            tbl = imm_tbl;
        end
    end

    initial begin
        AST_TABLE_RATIO: assert (TW == 2 * BW); // R3
    end
endmodule

// File: rtl/bitlut_lanes.sv
module bitlut_lanes #(
    parameter int W  = 64,
    parameter int TW = 8
) (
    input  logic [TW-1:0] tbl,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic [W-1:0]  c,
    output logic [W-1:0]  y
);
    localparam int IW = $clog2(TW);

    for (genvar i = 0; i < W; i++) begin : g_lane
        logic [IW-1:0] idx;
        assign idx  = {a[i], b[i], c[i]};
        assign y[i] = tbl[idx];
    end
endmodule

// File: rtl/bitlut_merge.sv
module bitlut_merge #(
    parameter int W  = 64,
    parameter int FW = 4
) (
    input  logic          field_mode,
    input  logic [FW-1:0] mask,
    input  logic [FW-1:0] prev,
    input  logic [W-1:0]  raw,
    output logic [W-1:0]  y
);
    logic [FW-1:0] merged;

    always_comb begin
        merged = (raw[FW-1:0] & mask) | (prev & ~mask);
        if (field_mode) begin
            y = '0;
            y[FW-1:0] = merged;
        end else begin
            y = raw;
        end
    end
endmodule

// File: rtl/bitlut_unit.sv
module bitlut_unit
    import bitlut_pkg::*;
#(
    parameter int W  = 64,
    parameter int FW = 4,
    parameter int TW = TRI_ENTRIES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [1:0]    mode,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    input  logic [W-1:0]  opc,
    input  logic [TW-1:0] imm,
    input  logic [FW-1:0] wmask,
    input  logic [FW-1:0] fld_prev,
    output logic          out_valid,
    output logic [W-1:0]  result
);
    localparam int BW = TW / 2;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] res;
    } unit_state_t;

    unit_state_t st_d, st_q;

    lut_mode_e     mode_e;
    logic [TW-1:0] tbl;
    logic [W-1:0]  lane_y;
    logic [W-1:0]  merged_y;

    assign mode_e = lut_mode_e'(mode);

    bitlut_table_sel #(.TW(TW), .BW(BW)) u_tsel (
        .mode    (mode_e),
        .imm_tbl (imm),
        .rt_tbl  (opc[BW-1:0]),
        .tbl     (tbl)
    );

    bitlut_lanes #(.W(W), .TW(TW)) u_lanes (
        .tbl (tbl),
        .a   (opa),
        .b   (opb),
        .c   (opc),
        .y   (lane_y)
    );

    bitlut_merge #(.W(W), .FW(FW)) u_merge (
        .field_mode (mode_is_field(mode_e)),
        .mask       (wmask),
        .prev       (fld_prev),
        .raw        (lane_y),
        .y          (merged_y)
    );

    always_comb begin
        st_d = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = merged_y;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;

    AST_VALID_ONE_LATER: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R8
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(result)); // R8
    AST_FIELD_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst) (in_valid && mode[1]) |=> (result[W-1:FW] == '0)); // R4
    AST_MASKED_BITS_KEPT: assert property (@(posedge clk) disable iff (rst) (in_valid && mode[1]) |=> (((result[FW-1:0] ^ $past(fld_prev)) & ~$past(wmask)) == '0)); // R6
    AST_MUX_TABLE: assert property (@(posedge clk) disable iff (rst) (in_valid && mode == 2'b00 && imm == 8'hCA) |=> (result == (($past(opa) & $past(opb)) | (~$past(opa) & $past(opc))))); // R2
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!out_valid && result == '0)); // R9
endmodule

// File: tb/bitlut_unit_test.sv
module bitlut_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [63:0] opa = '0, opb = '0, opc = '0;
    logic [7:0]  imm = '0;
    logic [3:0]  wmask = '0, fld_prev = '0;
    logic        out_valid;
    logic [63:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // model state
    logic        exp_vld = 1'b0;
    logic [63:0] exp_res = '0;
    string       exp_tag = "R9";

    always #(CLK_PERIOD/2) clk = ~clk;

    bitlut_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
        .opa(opa), .opb(opb), .opc(opc), .imm(imm),
        .wmask(wmask), .fld_prev(fld_prev),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] model(input logic [1:0] m, input logic [63:0] a,
                                          input logic [63:0] b, input logic [63:0] c,
                                          input logic [7:0] t, input logic [3:0] mk,
                                          input logic [3:0] pv);
        logic [63:0] r;
        int lim;
        r = '0;
        lim = m[1] ? 4 : 64;
        for (int i = 0; i < lim; i++) begin
            int k;
            logic bitv;
            if (m[0]) begin
                k = 2 * int'(a[i]) + int'(b[i]);
                bitv = c[k];
            end else begin
                k = 4 * int'(a[i]) + 2 * int'(b[i]) + int'(c[i]);
                bitv = t[k];
            end
            if (m[1] && !mk[i]) bitv = pv[i];
            r[i] = bitv;
        end
        return r;
    endfunction

    task automatic compare();
        n_checks++;
        if (out_valid !== exp_vld) begin
            n_fail++;
            $display("FAIL %s out_valid actual=%0b expected=%0b", exp_tag, out_valid, exp_vld);
        end
        n_checks++;
        if (result !== exp_res) begin
            n_fail++;
            $display("FAIL %s result actual=%h expected=%h", exp_tag, result, exp_res);
        end
    endtask

    // One clock: check what the previous cycle produced, then drive this cycle.
    task automatic cyc(input logic r, input logic v, input logic [1:0] m,
                       input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
                       input logic [7:0] t, input logic [3:0] mk, input logic [3:0] pv,
                       input string tag);
        @(negedge clk);
        compare();
        rst = r; in_valid = v; mode = m; opa = a; opb = b; opc = c;
        imm = t; wmask = mk; fld_prev = pv;
        if (r) begin
            exp_vld = 1'b0; exp_res = '0; exp_tag = "R9";
        end else begin
            exp_vld = v;
            if (v) begin
                exp_res = model(m, a, b, c, t, mk, pv);
                exp_tag = tag;
            end else begin
                exp_tag = "R8";
            end
        end
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 2'b10, 64'hFFFF_0000_AAAA_5555, 64'h1234, 64'h7, 8'h3C, 4'hF, 4'h9, "R8");
    endtask

    function automatic logic [63:0] r64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        logic [63:0] a, b, c;
        exp_tag = "R9";
        // reset state
        repeat (3) cyc(1'b1, 1'b0, 2'b00, '0, '0, '0, '0, '0, '0, "R9");
        idle();
        // R2 bitwise mux
        a = 64'hF0F0_0F0F_FF00_00FF; b = 64'hAAAA_AAAA_5555_5555; c = 64'h3333_CCCC_3333_CCCC;
        cyc(1'b0, 1'b1, 2'b00, a, b, c, 8'hCA, 4'h0, 4'h0, "R2");
        @(negedge clk);
        n_checks++;
        if (result !== ((a & b) | (~a & c))) begin
            n_fail++;
            $display("FAIL R2 mux actual=%h expected=%h", result, (a & b) | (~a & c));
        end
        compare();
        // R1 ternary register: xor3, majority, constants
        cyc(1'b0, 1'b1, 2'b00, r64(), r64(), r64(), 8'h96, 4'h3, 4'h1, "R1");
        cyc(1'b0, 1'b1, 2'b00, r64(), r64(), r64(), 8'hE8, 4'h0, 4'h0, "R1");
        cyc(1'b0, 1'b1, 2'b00, r64(), r64(), r64(), 8'hFF, 4'h0, 4'h0, "R1");
        cyc(1'b0, 1'b1, 2'b00, r64(), r64(), r64(), 8'h00, 4'h0, 4'h0, "R1");
        idle(); idle();
        // R3 binary register: AND, XOR, table from low bits of opc only
        cyc(1'b0, 1'b1, 2'b01, r64(), r64(), 64'hFFFF_FFFF_FFFF_FFF8, 8'h5A, 4'h6, 4'hC, "R3");
        cyc(1'b0, 1'b1, 2'b01, r64(), r64(), 64'h0000_0000_0000_0006, 8'hFF, 4'hF, 4'hF, "R3");
        cyc(1'b0, 1'b1, 2'b01, r64(), r64(), 64'hABCD_0000_0000_00F1, 8'h00, 4'h0, 4'h0, "R3");
        // R4 ternary field, full mask, upper operand garbage (R7)
        cyc(1'b0, 1'b1, 2'b10, r64(), r64(), r64(), 8'hCA, 4'hF, 4'h0, "R4");
        cyc(1'b0, 1'b1, 2'b10, 64'hFFFF_FFFF_FFFF_FFF0, 64'hFFFF_FFFF_FFFF_FFF0, 64'hFFFF_FFFF_FFFF_FFF0, 8'h01, 4'hF, 4'h0, "R7");
        // R6 mask cases
        cyc(1'b0, 1'b1, 2'b10, r64(), r64(), r64(), 8'hFF, 4'h0, 4'hA, "R6");
        cyc(1'b0, 1'b1, 2'b10, r64(), r64(), r64(), 8'hFF, 4'h5, 4'h0, "R6");
        cyc(1'b0, 1'b1, 2'b11, r64(), r64(), 64'h0, 4'h0, 4'h9, 4'hF, "R6");
        // R5 binary field
        cyc(1'b0, 1'b1, 2'b11, r64(), r64(), 64'hFFFF_0000_0000_0008, 8'h77, 4'hF, 4'h0, "R5");
        cyc(1'b0, 1'b1, 2'b11, r64(), r64(), 64'h0000_0000_0000_00FE, 8'h00, 4'hF, 4'h3, "R5");
        idle(); idle(); idle();
        // R9 reset together with a request
        cyc(1'b1, 1'b1, 2'b00, r64(), r64(), r64(), 8'hFF, 4'h0, 4'h0, "R9");
        idle();
        // back-to-back requests with mode changes every cycle, random gaps
        for (int n = 0; n < 400; n++) begin
            logic [1:0] m;
            string tg;
            m = 2'($urandom());
            case (m)
                2'b00: tg = "R1";
                2'b01: tg = "R3";
                2'b10: tg = "R4";
                default: tg = "R5";
            endcase
            cyc(1'b0, ($urandom() % 4) != 0, m, r64(), r64(), r64(), 8'($urandom()),
                4'($urandom()), 4'($urandom()), tg);
        end
        idle(); idle();
        @(negedge clk);
        compare();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule